// File: doc/BRIEF.md
# Programmable Parallel Port Core

This block gives a processor three 8-bit general-purpose I/O ports behind one small register window. Ports A and B move as whole bytes. Port C is handled as two independent 4-bit halves, and any single bit of it can also be forced high or low with one command. Each pin has a separate output value and output enable, so the pad ring builds the tri-state driver. Each pin also returns its live level for reads.

The processor selects the block with an active-low chip select. It picks one of four locations with a two-bit address: 0 = port A, 1 = port B, 2 = port C, 3 = control. It moves bytes with active-low read and write strobes. A write lands on the rising clock edge of every cycle in which chip select and the write strobe are both low. Read data is combinational and is zero while no read is in progress.

A byte written to the control location has one of two meanings, chosen by its top bit. With bit 7 = 1 it is a configuration byte. Bits 4, 3, 1 and 0 set the direction of port A, port C upper half, port B and port C lower half, where 1 means input. The handshake mode fields (bits 6:5 and bit 2) are stored and read back only. With bit 7 = 0 the byte is a single-bit command on port C: bits 3:1 give the bit index and bit 0 gives the new value. The handshake behaviour tied to the mode fields is provided by other blocks.

Top module: `ppio_core`

## Requirements
- R1: After reset every output enable is low and every output latch is zero. A control read returns 0x9B, meaning every port is an input and all mode fields are zero.
- R2: A configuration write (address 3, bit 7 = 1) sets the output enables. Port A follows bit 4, port C bits 7:4 follow bit 3, port B follows bit 1 and port C bits 3:0 follow bit 0. A 0 in the field drives all enables of that group high, and a 1 drives them low.
- R3: A configuration write clears the A, B and C output latches to zero. A later control read returns exactly the byte written, including the stored mode bits 6:5 and 2.
- R4: A write to address 0, 1 or 2 loads that port's output latch. The new value appears on the output pins from the clock edge that accepts the write.
- R5: A read of address 0, 1 or 2 returns the output latch for each group set as output and the live pin level for each group set as input. For port C this is chosen separately per half.
- R6: A single-bit command (address 3, bit 7 = 0) sets port C bit index bits 3:1 to the value of bit 0. All other port C latch bits keep their values.
- R7: A single-bit command leaves the stored control byte unchanged.
- R8: No latch or control state changes in a cycle in which chip select or the write strobe is high. The read data is zero unless chip select and the read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Location: 0 A, 1 B, 2 C, 3 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when idle |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, per half |

## Verification
The bench targets a port C read with one half as input and the other as output. A design that selected the source per byte would return the pins or the latch for both halves. Single-bit commands to bit 0 and bit 7 next to set neighbours expose index decoding that is off by one, or that disturbs other bits. A control readback after such a command catches a design that stores the command byte as configuration. Writes with chip select high and a configuration write over non-zero latches check that nothing leaks through without selection and that the clear actually happens.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
   localparam int unsigned BUS_W = 8;

   typedef enum logic [1:0] {
      LOC_A    = 2'd0,
      LOC_B    = 2'd1,
      LOC_C    = 2'd2,
      LOC_CTRL = 2'd3
   } loc_e;

   typedef struct packed {
      logic       is_cfg;
      logic [1:0] a_mode;
      logic       a_in;
      logic       cu_in;
      logic       b_mode;
      logic       b_in;
      logic       cl_in;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{is_cfg: 1'b1, a_mode: 2'b00, a_in: 1'b1,
                                  cu_in: 1'b1, b_mode: 1'b0, b_in: 1'b1,
                                  cl_in: 1'b1};
endpackage

// File: rtl/ppio_cfg_reg.sv
module ppio_cfg_reg
   import ppio_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_we,
   input  logic [BUS_W-1:0] wdata,
   output cfg_t             cfg,
   output logic             cfg_wr,
   output logic             bit_wr
);
   assign cfg_wr = ctrl_we &  wdata[BUS_W-1];
   assign bit_wr = ctrl_we & ~wdata[BUS_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= CFG_RESET;
      else if (cfg_wr) cfg <= cfg_t'(wdata);
   end

   // R3: configuration byte is stored verbatim
   p_cfg_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (cfg == cfg_t'($past(wdata))));
   // R7: a single-bit command never alters the configuration
   p_bit_keeps_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_we && !wdata[BUS_W-1]) |=> $stable(cfg));
endmodule

// File: rtl/ppio_lane.sv
module ppio_lane #(
   parameter int unsigned W     = 8,
   localparam int unsigned IDX_W = $clog2(W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             bit_wr,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             bit_val,
   input  logic             dir_in,
   input  logic [W-1:0]     pin_in,
   output logic [W-1:0]     pin_out,
   output logic [W-1:0]     pin_oe,
   output logic [W-1:0]     rd_val
);
   if (W < 2) begin : g_bad_w
      $error("ppio_lane: W must be at least 2");
   end

   logic [W-1:0] latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_q <= '0;
      else if (clr)    latch_q <= '0;
      else if (wr_en)  latch_q <= wr_data;
      else if (bit_wr) latch_q[bit_idx] <= bit_val;
   end

   assign pin_out = latch_q;
   assign pin_oe  = {W{~dir_in}};
   assign rd_val  = dir_in ? pin_in : latch_q;

   // R3: configuration write empties the latch
   p_clr_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pin_out == '0));

   for (genvar i = 0; i < W; i++) begin : g_bit_chk
      // R6: untargeted bits hold through a single-bit command
      p_bit_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_wr && !clr && !wr_en && (bit_idx != IDX_W'(i))) |=> $stable(pin_out[i]));
      p_bit_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (bit_wr && !clr && !wr_en && (bit_idx == IDX_W'(i))) |=> (pin_out[i] == $past(bit_val)));
   end
endmodule

// File: rtl/ppio_core.sv
module ppio_core
   import ppio_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned HALF_W = DATA_W / 2,
   localparam int unsigned HIDX_W = $clog2(HALF_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe,
   input  logic [DATA_W-1:0] pc_in,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] pc_oe
);
   if (DATA_W != BUS_W) begin : g_bad_w
      $error("ppio_core: DATA_W must equal the control byte width");
   end

   logic  wr_sel, rd_sel, cfg_wr, bit_wr;
   cfg_t  cfg;
   logic [DATA_W-1:0] ra, rb, rc;

   assign wr_sel = ~cs_n & ~wr_n;
   assign rd_sel = ~cs_n & ~rd_n;

   ppio_cfg_reg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ctrl_we (wr_sel && addr == LOC_CTRL),
      .wdata   (wdata),
      .cfg     (cfg),
      .cfg_wr  (cfg_wr),
      .bit_wr  (bit_wr)
   );

   ppio_lane #(.W(DATA_W)) u_pa (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr),
      .wr_en(wr_sel && addr == LOC_A), .wr_data(wdata),
      .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0),
      .dir_in(cfg.a_in), .pin_in(pa_in),
      .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(ra)
   );

   ppio_lane #(.W(DATA_W)) u_pb (
      .clk(clk), .rst_n(rst_n), .clr(cfg_wr),
      .wr_en(wr_sel && addr == LOC_B), .wr_data(wdata),
      .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0),
      .dir_in(cfg.b_in), .pin_in(pb_in),
      .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rb)
   );

   // Port C: two half lanes; index bit 3 of the command selects the half
   for (genvar h = 0; h < 2; h++) begin : g_pc
      logic [HALF_W-1:0] rd_h;
      ppio_lane #(.W(HALF_W)) u_half (
         .clk(clk), .rst_n(rst_n), .clr(cfg_wr),
         .wr_en(wr_sel && addr == LOC_C),
         .wr_data(wdata[h*HALF_W +: HALF_W]),
         .bit_wr(bit_wr && (wdata[HIDX_W+1] == 1'(h))),
         .bit_idx(wdata[HIDX_W:1]),
         .bit_val(wdata[0]),
         .dir_in((h == 0) ? cfg.cl_in : cfg.cu_in),
         .pin_in(pc_in[h*HALF_W +: HALF_W]),
         .pin_out(pc_out[h*HALF_W +: HALF_W]),
         .pin_oe(pc_oe[h*HALF_W +: HALF_W]),
         .rd_val(rd_h)
      );
      assign rc[h*HALF_W +: HALF_W] = rd_h;
   end

   always_comb begin
      rdata = '0;
      if (rd_sel) begin
         unique case (addr)
            LOC_A:    rdata = ra;
            LOC_B:    rdata = rb;
            LOC_C:    rdata = rc;
            default:  rdata = DATA_W'(cfg);
         endcase
      end
   end

   // R8: without a selected write, no latch moves
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || wr_n) |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));
   // R8: bus is quiet when no read is in progress
   p_idle_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || rd_n) |-> (rdata == '0));
   // R4: a port A write is visible after the accepting edge
   p_wr_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel && addr == LOC_A) |=> (pa_out == $past(wdata)));
endmodule

// File: tb/ppio_core_bench.sv
module ppio_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic [7:0] pa_in = 8'd0, pb_in = 8'd0, pc_in = 8'd0;
   logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // model state
   logic [7:0] m_cfg = 8'h9B;
   logic [7:0] m_a = 8'h00, m_b = 8'h00, m_c = 8'h00;

   always #4 clk = ~clk;

   ppio_core u_ppio_core (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   function automatic logic [7:0] f_oe_a(input logic [7:0] c); return c[4] ? 8'h00 : 8'hFF; endfunction
   function automatic logic [7:0] f_oe_b(input logic [7:0] c); return c[1] ? 8'h00 : 8'hFF; endfunction
   function automatic logic [7:0] f_oe_c(input logic [7:0] c);
      return {c[3] ? 4'h0 : 4'hF, c[0] ? 4'h0 : 4'hF};
   endfunction

   function automatic logic [7:0] f_read(input logic [1:0] a);
      case (a)
         2'd0: return m_cfg[4] ? pa_in : m_a;
         2'd1: return m_cfg[1] ? pb_in : m_b;
         2'd2: return {m_cfg[3] ? pc_in[7:4] : m_c[7:4], m_cfg[0] ? pc_in[3:0] : m_c[3:0]};
         default: return m_cfg;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic chk_pins(input string tag);
      chk({tag, " pa_out"}, pa_out, m_a);
      chk({tag, " pb_out"}, pb_out, m_b);
      chk({tag, " pc_out"}, pc_out, m_c);
      chk({tag, " pa_oe"}, pa_oe, f_oe_a(m_cfg));
      chk({tag, " pb_oe"}, pb_oe, f_oe_b(m_cfg));
      chk({tag, " pc_oe"}, pc_oe, f_oe_c(m_cfg));
   endtask

   task automatic model_write(input logic [1:0] a, input logic [7:0] d);
      case (a)
         2'd0: m_a = d;
         2'd1: m_b = d;
         2'd2: m_c = d;
         default: begin
            if (d[7]) begin
               m_cfg = d; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
            end else begin
               m_c[d[3:1]] = d[0];
            end
         end
      endcase
   endtask

   // drive on falling edge, accepted at rising edge, released next falling edge
   task automatic do_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      addr = a; wdata = d; cs_n = ~sel; wr_n = 1'b0;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      if (sel) model_write(a, d);
   endtask

   task automatic do_read(input logic [1:0] a, input string tag);
      @(negedge clk);
      addr = a; cs_n = 1'b0; rd_n = 1'b0;
      #1;
      chk(tag, rdata, f_read(a));
      @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_pins("R1 reset");
      do_read(2'd3, "R1 reset control readback");

      // R2/R4: all outputs, write each port
      do_write(2'd3, 8'h80, 1'b1);
      chk_pins("R2 all outputs");
      do_write(2'd0, 8'hA5, 1'b1);
      do_write(2'd1, 8'h3C, 1'b1);
      do_write(2'd2, 8'h81, 1'b1);
      chk_pins("R4 port writes");
      // R6: bit 0 cleared, bit 6 set, bit 7 cleared
      do_write(2'd3, 8'h00, 1'b1);
      chk_pins("R6 clear bit0");
      do_write(2'd3, 8'h0D, 1'b1);
      chk_pins("R6 set bit6");
      do_write(2'd3, 8'h0E, 1'b1);
      chk_pins("R6 clear bit7");
      do_read(2'd3, "R7 control unchanged after bit command");
      // R8: write with chip select high is ignored
      do_write(2'd0, 8'h5A, 1'b0);
      chk_pins("R8 deselected write");
      @(negedge clk);
      addr = 2'd0; cs_n = 1'b0; rd_n = 1'b1;
      #1 chk("R8 rdata idle", rdata, 8'h00);
      cs_n = 1'b1;
      // R3: configuration clears latches, mode bits read back
      do_write(2'd3, 8'hE4, 1'b1);
      chk_pins("R3 config clears");
      do_read(2'd3, "R3 control readback");
      // R5: mixed port C halves (upper input, lower output)
      do_write(2'd3, 8'h88, 1'b1);
      do_write(2'd2, 8'h6B, 1'b1);
      pc_in = 8'hD2;
      do_read(2'd2, "R5 mixed port C read");
      pc_in = 8'h00;
      do_write(2'd3, 8'h81, 1'b1);
      do_write(2'd2, 8'h6B, 1'b1);
      pc_in = 8'hD2;
      do_read(2'd2, "R5 mixed port C read swapped");

      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [1:0] a;
         logic [7:0] d;
         a = 2'($urandom_range(0, 3));
         d = 8'($urandom);
         pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
         case ($urandom_range(0, 4))
            0, 1: begin
               do_write(a, d, 1'b1);
               chk_pins((a == 2'd3) ? (d[7] ? "R2 R3 random config" : "R6 random bit cmd")
                                    : "R4 random port write");
            end
            2: begin
               do_write(a, d, 1'b0);
               chk_pins("R8 random deselected write");
            end
            default: do_read(a, (a == 2'd3) ? "R7 random control read" : "R5 random port read");
         endcase
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule